// File: doc/BRIEF.md
# Boundary Scan Test Access Port with Mixed-Cell Boundary Register

This block puts a serial test port between the core logic of a small device and its pads. A four-wire serial interface (test clock, mode select, data in, data out) and an optional asynchronous reset drive the standard sixteen-state controller. The controller moves data through a two-bit instruction register, a one-bit bypass register, or a boundary register. The boundary register sits between the core and the pads. Each three-state bidirectional pad has three cells: one captures the pad input, one holds the output value and one holds the output enable. Each input-only pad has one capture cell. All cells form a single chain.

Three instructions are supported. The first mode leaves the pads under core control and takes a snapshot of pad and core values. The second mode hands the output and enable pads to the boundary update latches, so board wiring can be tested. Every other code selects the one-bit bypass path. In any mode other than the pad-driving test, core values go straight to the pads. Pad inputs always reach the core unchanged.

Top module: `bscan_tap_top`

## Requirements
- R1: While `trst_n` is low and after its release, the instruction is BYPASS: `pad_dout`/`pad_den` equal `core_dout`/`core_den` and `tdo_oe` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the instruction becomes BYPASS on that same edge.
- R3: At Capture-IR the instruction shift register loads 2'b01. The register shifts toward `tdo`, least significant bit first, so the first two `tdo` bits of Shift-IR are 1 then 0.
- R4: Instruction 2'b11 (BYPASS) selects a one-bit register that loads 0 at Capture-DR, so `tdo` in Shift-DR shows 0 and then `tdi` delayed by one `tck`.
- R5: Instruction 2'b01 (SAMPLE) loads the boundary register at Capture-DR. During capture, shift and update the pads keep following the core.
- R6: Instruction 2'b00 (EXTEST) drives `pad_dout` and `pad_den` from the boundary update latches. Changes on `core_dout`/`core_den` have no effect on the pads.
- R7: The unassigned code 2'b10 behaves exactly like BYPASS.
- R8: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo` changes only on the falling edge of `tck`.
- R9: `core_din` equals `pad_din` and `core_din_bidir` equals `pad_din_bidir` in every mode.
- R10: The boundary chain is ordered by cell index from `tdo` (index 0) to `tdi`. Bidirectional pad k uses index 3k (captured input), 3k+1 (output) and 3k+2 (enable). Input pad j uses index 3*N_BIDIR+j. The output and enable cells capture `core_dout`/`core_den`.
- R11: The update latches change only on the rising edge that leaves Update-DR. Shifting and Pause-DR leave the pads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Enable for the `tdo` pad driver |
| core_dout | input | N_BIDIR | Core output values for the bidirectional pads |
| core_den | input | N_BIDIR | Core output enables for the bidirectional pads |
| core_din_bidir | output | N_BIDIR | Bidirectional pad inputs delivered to the core |
| core_din | output | N_IN | Input-only pad values delivered to the core |
| pad_dout | output | N_BIDIR | Output value to each bidirectional pad |
| pad_den | output | N_BIDIR | Output enable to each bidirectional pad |
| pad_din_bidir | input | N_BIDIR | Value received at each bidirectional pad |
| pad_din | input | N_IN | Value received at each input-only pad |

## Verification
The bench runs a table of pad and core patterns through the pad-driving test mode. It checks that every cell lands at its stated chain position. A design with the three cells of a pad swapped, or the input cells placed first, would return a permuted capture word and drive the wrong pads. It parks in Pause-DR to catch latches that update early, and it toggles the core after an update to catch a pad mux that still listens to the core. The undefined opcode, the bypass delay of exactly one clock, the Capture-IR pattern, the edge on which `tdo` moves and the five-ones escape from Shift-IR each get a directed test. A controller with a wrong transition, or a `tdo` stage clocked on the rising edge, shows up as a shifted bit stream or pads that stay under test control.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  // Sixteen controller states
  typedef enum logic [3:0] {
    ST_TLR,
    ST_RTI,
    ST_SEL_DR,
    ST_CAP_DR,
    ST_SH_DR,
    ST_EX1_DR,
    ST_PAU_DR,
    ST_EX2_DR,
    ST_UPD_DR,
    ST_SEL_IR,
    ST_CAP_IR,
    ST_SH_IR,
    ST_EX1_IR,
    ST_PAU_IR,
    ST_EX2_IR,
    ST_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_SPARE  = 2'b10,
    OP_BYPASS = 2'b11
  } opcode_e;

  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 2'b01;

  // Cell offsets inside one bidirectional pad group
  localparam int unsigned CELLS_PER_BIDIR = 3;
  localparam int unsigned OFS_IN  = 0;
  localparam int unsigned OFS_OUT = 1;
  localparam int unsigned OFS_EN  = 2;

endpackage

// File: rtl/bscan_rst_sync.sv
`timescale 1ns/1ps
module bscan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bscan_tap_fsm.sv
`timescale 1ns/1ps
module bscan_tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_d
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TLR;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/bscan_instr_reg.sv
`timescale 1ns/1ps
module bscan_instr_reg
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            upd_en,
  input  logic            force_bypass,
  output logic            so,
  output logic [IR_W-1:0] ir_sr,
  output opcode_e         ir_q
);

  logic [IR_W-1:0] sr_d;
  opcode_e         ir_d;

  always_comb begin
    sr_d = ir_sr;
    if (cap_en) begin
      sr_d = IR_CAPTURE_VAL;
    end else if (shift_en) begin
      sr_d = {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_d = ir_q;
    if (force_bypass) begin
      ir_d = OP_BYPASS;
    end else if (upd_en) begin
      ir_d = opcode_e'(ir_sr);
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= IR_CAPTURE_VAL;
      ir_q  <= OP_BYPASS;
    end else begin
      ir_sr <= sr_d;
      ir_q  <= ir_d;
    end
  end

  assign so = ir_sr[0];

endmodule

// File: rtl/bscan_bsr.sv
`timescale 1ns/1ps
module bscan_bsr
  import bscan_pkg::*;
#(
  parameter int unsigned N_BIDIR = 2,
  parameter int unsigned N_IN    = 2
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tdi,
  input  logic               cap_en,
  input  logic               shift_en,
  input  logic               upd_en,
  input  logic [N_BIDIR-1:0] core_dout,
  input  logic [N_BIDIR-1:0] core_den,
  input  logic [N_BIDIR-1:0] pad_din_bidir,
  input  logic [N_IN-1:0]    pad_din,
  output logic               so,
  output logic [N_BIDIR-1:0] upd_dout,
  output logic [N_BIDIR-1:0] upd_den
);

  localparam int unsigned BIDIR_CELLS = N_BIDIR * CELLS_PER_BIDIR;
  localparam int unsigned CHAIN_LEN   = BIDIR_CELLS + N_IN;

  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] shift_vec;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] chain_d;

  // Three cells per bidirectional pad, each pad with its own update latches
  for (genvar g = 0; g < N_BIDIR; g++) begin : g_bidir
    localparam int unsigned BASE = g * CELLS_PER_BIDIR;
    logic dout_q;
    logic den_q;

    assign cap_vec[BASE + OFS_IN]  = pad_din_bidir[g];
    assign cap_vec[BASE + OFS_OUT] = core_dout[g];
    assign cap_vec[BASE + OFS_EN]  = core_den[g];

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        dout_q <= 1'b0;
        den_q  <= 1'b0;
      end else if (upd_en) begin
        dout_q <= chain_q[BASE + OFS_OUT];
        den_q  <= chain_q[BASE + OFS_EN];
      end
    end

    assign upd_dout[g] = dout_q;
    assign upd_den[g]  = den_q;
  end

  // One capture-only cell per input pad
  for (genvar g = 0; g < N_IN; g++) begin : g_input
    assign cap_vec[BIDIR_CELLS + g] = pad_din[g];
  end

  // Serial path: the top cell takes tdi, every other cell takes its upper neighbour
  for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_link
    if (k == CHAIN_LEN - 1) begin : g_head
      assign shift_vec[k] = tdi;
    end else begin : g_body
      assign shift_vec[k] = chain_q[k+1];
    end
  end

  always_comb begin
    chain_d = chain_q;
    if (cap_en) begin
      chain_d = cap_vec;
    end else if (shift_en) begin
      chain_d = shift_vec;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign so = chain_q[0];

endmodule

// File: rtl/bscan_tap_top.sv
`timescale 1ns/1ps
module bscan_tap_top
  import bscan_pkg::*;
#(
  parameter int unsigned N_BIDIR = 2,
  parameter int unsigned N_IN    = 2
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [N_BIDIR-1:0] core_dout,
  input  logic [N_BIDIR-1:0] core_den,
  output logic [N_BIDIR-1:0] core_din_bidir,
  output logic [N_IN-1:0]    core_din,
  output logic [N_BIDIR-1:0] pad_dout,
  output logic [N_BIDIR-1:0] pad_den,
  input  logic [N_BIDIR-1:0] pad_din_bidir,
  input  logic [N_IN-1:0]    pad_din
);

  logic            rst_n;
  tap_state_e      state_q;
  tap_state_e      state_d;
  opcode_e         ir_q;
  logic [IR_W-1:0] ir_sr;
  logic            ir_so;
  logic            bsr_so;
  logic            byp_q;
  logic            byp_d;
  logic [N_BIDIR-1:0] upd_dout;
  logic [N_BIDIR-1:0] upd_den;

  logic cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir, enter_tlr;
  logic bsr_sel, drive_pads;
  logic tdo_d, tdo_oe_d;

  bscan_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  bscan_tap_fsm u_fsm (
    .tck     (tck),
    .rst_n   (rst_n),
    .tms     (tms),
    .state_q (state_q),
    .state_d (state_d)
  );

  assign cap_dr    = (state_q == ST_CAP_DR);
  assign sh_dr     = (state_q == ST_SH_DR);
  assign upd_dr    = (state_q == ST_UPD_DR);
  assign cap_ir    = (state_q == ST_CAP_IR);
  assign sh_ir     = (state_q == ST_SH_IR);
  assign upd_ir    = (state_q == ST_UPD_IR);
  assign enter_tlr = (state_d == ST_TLR);

  bscan_instr_reg u_ir (
    .tck          (tck),
    .rst_n        (rst_n),
    .tdi          (tdi),
    .cap_en       (cap_ir),
    .shift_en     (sh_ir),
    .upd_en       (upd_ir),
    .force_bypass (enter_tlr),
    .so           (ir_so),
    .ir_sr        (ir_sr),
    .ir_q         (ir_q)
  );

  // Decode: only the two boundary opcodes select the chain, all others bypass
  assign drive_pads = (ir_q == OP_EXTEST);
  assign bsr_sel    = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE);

  bscan_bsr #(.N_BIDIR(N_BIDIR), .N_IN(N_IN)) u_bsr (
    .tck           (tck),
    .rst_n         (rst_n),
    .tdi           (tdi),
    .cap_en        (cap_dr & bsr_sel),
    .shift_en      (sh_dr & bsr_sel),
    .upd_en        (upd_dr & bsr_sel),
    .core_dout     (core_dout),
    .core_den      (core_den),
    .pad_din_bidir (pad_din_bidir),
    .pad_din       (pad_din),
    .so            (bsr_so),
    .upd_dout      (upd_dout),
    .upd_den       (upd_den)
  );

  // One-bit bypass path
  always_comb begin
    byp_d = byp_q;
    if (cap_dr && !bsr_sel) begin
      byp_d = 1'b0;
    end else if (sh_dr && !bsr_sel) begin
      byp_d = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else begin
      byp_q <= byp_d;
    end
  end

  // Output stage on the falling edge
  always_comb begin
    tdo_oe_d = sh_dr | sh_ir;
    tdo_d    = tdo;
    if (sh_ir) begin
      tdo_d = ir_so;
    end else if (sh_dr) begin
      tdo_d = bsr_sel ? bsr_so : byp_q;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= tdo_oe_d;
    end
  end

  // Pad and core muxing
  assign pad_dout       = drive_pads ? upd_dout : core_dout;
  assign pad_den        = drive_pads ? upd_den  : core_den;
  assign core_din_bidir = pad_din_bidir;
  assign core_din       = pad_din;

endmodule

// File: rtl/bscan_checker.sv
`timescale 1ns/1ps
module bscan_checker
  import bscan_pkg::*;
#(
  parameter int unsigned N_BIDIR = 2
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tms,
  input tap_state_e         state_q,
  input opcode_e            ir_q,
  input logic [IR_W-1:0]    ir_sr,
  input logic               tdo_oe,
  input logic [N_BIDIR-1:0] core_dout,
  input logic [N_BIDIR-1:0] core_den,
  input logic [N_BIDIR-1:0] pad_dout,
  input logic [N_BIDIR-1:0] pad_den
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ones_cnt <= 3'd0;
    end else if (!tms) begin
      ones_cnt <= 3'd0;
    end else if (ones_cnt != 3'd5) begin
      ones_cnt <= ones_cnt + 3'd1;
    end
  end

  p_tlr_bypass_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == ST_TLR) |-> (ir_q == OP_BYPASS));

  p_five_ones_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_cnt == 3'd5) |-> (state_q == ST_TLR));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE_VAL));

  p_core_owns_pads_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q != OP_EXTEST) |-> (pad_dout == core_dout && pad_den == core_den));

  p_tdo_oe_shift_r8: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (state_q == ST_SH_DR || state_q == ST_SH_IR));

  p_extest_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q == OP_EXTEST && $past(ir_q) == OP_EXTEST && $past(state_q) != ST_UPD_DR)
      |-> ($stable(pad_dout) && $stable(pad_den)));

endmodule

bind bscan_tap_top bscan_checker #(.N_BIDIR(N_BIDIR)) u_checker (
  .tck       (tck),
  .rst_n     (rst_n),
  .tms       (tms),
  .state_q   (state_q),
  .ir_q      (ir_q),
  .ir_sr     (ir_sr),
  .tdo_oe    (tdo_oe),
  .core_dout (core_dout),
  .core_den  (core_den),
  .pad_dout  (pad_dout),
  .pad_den   (pad_den)
);

// File: tb/bscan_tap_top_bench.sv
`timescale 1ns/1ps
module bscan_tap_top_bench;

  localparam int unsigned NB = 2;
  localparam int unsigned NI = 2;
  localparam int unsigned CHAIN = 3*NB + NI;

  // {core_dout, core_den, pad_din_bidir, pad_din, shift word, capture word, pad_dout, pad_den}
  localparam int NVEC = 4;
  localparam logic [27:0] VEC [NVEC] = '{
    {2'b01, 2'b11, 2'b10, 2'b01, 8'h36, 8'h6E, 2'b11, 2'b11},
    {2'b10, 2'b00, 2'b01, 2'b10, 8'hC9, 8'h91, 2'b00, 2'b00},
    {2'b11, 2'b01, 2'b11, 2'b11, 8'h12, 8'hDF, 2'b11, 2'b00},
    {2'b00, 2'b10, 2'b00, 2'b00, 8'h24, 8'h20, 2'b00, 2'b11}
  };

  logic          tck;
  logic          trst_n;
  logic          tms;
  logic          tdi;
  logic          tdo;
  logic          tdo_oe;
  logic [NB-1:0] core_dout;
  logic [NB-1:0] core_den;
  logic [NB-1:0] core_din_bidir;
  logic [NI-1:0] core_din;
  logic [NB-1:0] pad_dout;
  logic [NB-1:0] pad_den;
  logic [NB-1:0] pad_din_bidir;
  logic [NI-1:0] pad_din;

  int  n_run;
  int  n_fail;
  bit  done;

  bscan_tap_top #(.N_BIDIR(NB), .N_IN(NI)) u_bscan_tap_top (
    .tck            (tck),
    .trst_n         (trst_n),
    .tms            (tms),
    .tdi            (tdi),
    .tdo            (tdo),
    .tdo_oe         (tdo_oe),
    .core_dout      (core_dout),
    .core_den       (core_den),
    .core_din_bidir (core_din_bidir),
    .core_din       (core_din),
    .pad_dout       (pad_dout),
    .pad_den        (pad_den),
    .pad_din_bidir  (pad_din_bidir),
    .pad_din        (pad_din)
  );

  initial tck = 1'b0;
  always #10 tck = ~tck;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic reset_tap();
    trst_n = 1'b0;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    trst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle: load an opcode (bit 0 first), return the captured bits
  task automatic load_ir(input logic [1:0] op, output logic [1:0] cap);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    cap[0] = tdo;
    step(1'b0, op[0]);
    cap[1] = tdo;
    step(1'b1, op[1]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle: shift n bits, stop in Exit1-DR
  task automatic shift_dr(input int n, input logic [15:0] w, output logic [15:0] got);
    got = '0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      step(i == n-1, w[i]);
    end
  endtask

  task automatic finish_update();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0]  cap;
    logic [15:0] got;
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    tms = 1'b1;
    tdi = 1'b0;
    trst_n = 1'b0;
    core_dout = 2'b10;
    core_den = 2'b01;
    pad_din_bidir = 2'b01;
    pad_din = 2'b11;

    // Reset state
    reset_tap();
    check("R1", "pad_dout after reset", pad_dout, core_dout);
    check("R1", "pad_den after reset", pad_den, core_den);
    check("R1", "tdo_oe after reset", tdo_oe, 1'b0);
    check("R9", "core_din", core_din, pad_din);

    // Bypass: captured 0 then tdi delayed one clock
    shift_dr(4, 16'h000D, got);
    check("R4", "bypass stream", got[3:0], 4'b1010);
    check("R8", "tdo_oe in Exit1-DR", tdo_oe, 1'b0);
    finish_update();

    // TDO moves on the falling edge
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R8", "tdo_oe in Shift-DR", tdo_oe, 1'b1);
    check("R8", "tdo first bypass bit", tdo, 1'b0);
    tms = 1'b0;
    tdi = 1'b1;
    @(posedge tck);
    #1;
    check("R8", "tdo held after rising edge", tdo, 1'b0);
    @(negedge tck);
    #1;
    check("R8", "tdo after falling edge", tdo, 1'b1);
    step(1'b1, 1'b0);
    finish_update();

    // Capture-IR value and SAMPLE
    load_ir(2'b01, cap);
    check("R3", "Capture-IR bits", cap, 2'b01);
    core_dout = VEC[0][27:26];
    core_den = VEC[0][25:24];
    pad_din_bidir = VEC[0][23:22];
    pad_din = VEC[0][21:20];
    shift_dr(CHAIN, 16'h00FF, got);
    check("R5", "pads during SAMPLE shift", {pad_dout, pad_den}, {core_dout, core_den});
    finish_update();
    check("R5", "SAMPLE capture word", got[7:0], VEC[0][11:4]);
    check("R5", "pads after SAMPLE update", {pad_dout, pad_den}, {core_dout, core_den});

    // Spare opcode acts as bypass
    load_ir(2'b10, cap);
    shift_dr(4, 16'h000D, got);
    finish_update();
    check("R7", "spare opcode stream", got[3:0], 4'b1010);
    check("R7", "spare opcode pads", {pad_dout, pad_den}, {core_dout, core_den});

    // EXTEST table
    load_ir(2'b00, cap);
    for (int v = 0; v < NVEC; v++) begin
      core_dout = VEC[v][27:26];
      core_den = VEC[v][25:24];
      pad_din_bidir = VEC[v][23:22];
      pad_din = VEC[v][21:20];
      shift_dr(CHAIN, {8'h00, VEC[v][19:12]}, got);
      finish_update();
      check("R10", "EXTEST capture order", got[7:0], VEC[v][11:4]);
      check("R6", "pad_dout from latch", pad_dout, VEC[v][3:2]);
      check("R6", "pad_den from latch", pad_den, VEC[v][1:0]);
      core_dout = ~core_dout;
      core_den = ~core_den;
      #1;
      check("R6", "core ignored in EXTEST", {pad_dout, pad_den}, VEC[v][3:0]);
      check("R9", "inputs reach core in EXTEST", {core_din_bidir, core_din}, {pad_din_bidir, pad_din});
    end

    // Pause-DR leaves latches alone (current: dout 00, den 11)
    shift_dr(CHAIN, 16'h0012, got);
    step(1'b0, 1'b0);
    check("R11", "pads in Pause-DR", {pad_dout, pad_den}, 4'b0011);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check("R11", "pads after Update-DR", {pad_dout, pad_den}, 4'b1100);

    // Five ones from Shift-IR
    core_dout = 2'b00;
    core_den = 2'b11;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    repeat (5) step(1'b1, 1'b1);
    check("R2", "pads after five ones", {pad_dout, pad_den}, 4'b0011);
    check("R2", "tdo_oe in Test-Logic-Reset", tdo_oe, 1'b0);

    // Asynchronous reset during EXTEST
    step(1'b0, 1'b0);
    load_ir(2'b00, cap);
    check("R6", "EXTEST latches drive pads", {pad_dout, pad_den}, 4'b1100);
    trst_n = 1'b0;
    #1;
    check("R1", "pads under trst_n", {pad_dout, pad_den}, {core_dout, core_den});
    reset_tap();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule